// File: doc/BRIEF.md
# Supply Rail Protection Shutdown Controller

The block watches three supply rails through over-limit and under-limit flags produced by an external comparator. Software selects which rails may trigger a protective shutdown, reads a sticky fault flag and sets two timing fields through a small byte-wide register port. A fault is recognised only when the block is armed. Arming requires power-good. When the strap-sampled protection mode is set, it also waits for a programmable delay after power-good rises.

On a fault, the block latches the fault flag. It then releases the power-supply-on output to high impedance for a programmable hold time. The output is modelled as a data signal plus an output enable. Outside a hold, the output is driven as the inverse of the sleep-state input. All intervals are counted on a tick-enable input, so the real-time values scale with the tick rate.

Register map, using the 2-bit address: 0 is the rail enable, 1 is the fault flag, 2 is the timing configuration, and 3 reads zero.

Top module: `vprot_shutdown`

## Requirements
- R1: After reset the rail-enable register reads 0x00, the fault flag reads 0x00 and the configuration register reads 0x06, which is hold field 01 and arming field 10. The output is enabled and carries the inverse of the sleep input.
- R2: In the rail-enable register, bit 0 enables rail 0 (the 3.3 V rail), bit 5 enables rail 1 and bit 6 enables rail 2. Bits 7 and 4..1 always read 0.
- R3: While armed, if either the over flag or the under flag of an enabled rail is high, the fault flag (address 1, bit 0) reads 1 after the next clock edge. In the same cycle the output enable goes low.
- R4: Writing a byte with bit 0 set to address 1 clears the fault flag. Writing bit 0 as 0 leaves it unchanged. The flag otherwise stays set.
- R5: A flag on a rail whose enable bit is 0 has no effect, and so does a flag while power-good is low. The fault flag stays 0 and the output stays enabled.
- R6: The configuration register is bits [3:2] hold and [1:0] arming. Hold codes 00, 01, 10 and 11 keep the output disabled for H, 2H, 4H and 8H ticks, where H is the half-second tick count.
- R7: Whenever the output is enabled, its data equals the inverse of the sleep input.
- R8: With protection mode 1, arming codes 01, 10 and 11 arm the block A, 2A and 4A ticks after power-good rises, where A is the 50 ms tick count.
- R9: With protection mode 0, or with arming code 00, the block arms on the first clock edge that sees power-good high.
- R10: A further fault during an active hold does not restart the hold time.
- R11: Power-good low disarms the block and restarts the arming delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base tick enable |
| pwr_good_i | input | 1 | Main supply good |
| prot_mode_i | input | 1 | Strap: apply the arming delay |
| ov_i | input | 3 | Per-rail over-limit flags |
| uv_i | input | 3 | Per-rail under-limit flags |
| slp_i | input | 1 | Sleep-state input |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| psu_on_o | output | 1 | Power-supply-on data |
| psu_on_oe_o | output | 1 | Power-supply-on output enable |

## Verification
On every cycle, the assertions check four things. A falling output enable always coincides with a set fault flag. The flag stays set until a clearing write and drops after one. Power-good low disarms the block and stops new faults. Reserved enable bits never read as one. The exact hold and arming lengths for each field code need the bench's scenarios, because those counts scale with parameters. So do the refusal to restart on a second fault and the restart of arming after a power-good dropout.

// File: rtl/vprot_pkg.sv
package vprot_pkg;
  localparam int unsigned NRAIL = 3;
  localparam int unsigned EN_POS [NRAIL] = '{0, 5, 6};

  typedef enum logic [1:0] {
    A_EN   = 2'd0,
    A_STAT = 2'd1,
    A_CFG  = 2'd2,
    A_RSV  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [1:0] hold_sel;
    logic [1:0] arm_sel;
  } cfg_t;

  localparam cfg_t CFG_RST = '{hold_sel: 2'b01, arm_sel: 2'b10};
endpackage

// File: rtl/vprot_regs.sv
module vprot_regs
  import vprot_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             fault_i,
  output logic [7:0]       rdata_o,
  output logic [NRAIL-1:0] en_o,
  output cfg_t             cfg_o,
  output logic             stat_o
);
  logic [NRAIL-1:0] en_q;
  cfg_t             cfg_q;
  logic             stat_q;
  logic             wr_en, wr_stat, wr_cfg;

  assign wr_en   = we_i && (addr_i == A_EN);
  assign wr_stat = we_i && (addr_i == A_STAT);
  assign wr_cfg  = we_i && (addr_i == A_CFG);

  for (genvar r = 0; r < NRAIL; r++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    en_q[r] <= 1'b0;
      else if (wr_en) en_q[r] <= wdata_i[EN_POS[r]];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RST;
      stat_q <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= cfg_t'(wdata_i[3:0]);
      // set wins over a same-cycle clear
      stat_q <= fault_i | (stat_q & ~(wr_stat & wdata_i[0]));
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_EN:   for (int r = 0; r < NRAIL; r++) rdata_o[EN_POS[r]] = en_q[r];
      A_STAT: rdata_o[0]   = stat_q;
      A_CFG:  rdata_o[3:0] = cfg_q;
      default: rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign cfg_o  = cfg_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/vprot_arm.sv
module vprot_arm #(
  parameter int unsigned ARM_UNIT_TICKS = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       pwr_good_i,
  input  logic       mode_i,
  input  logic [1:0] sel_i,
  output logic       armed_o
);
  localparam int unsigned AW = $clog2(4 * ARM_UNIT_TICKS + 1);

  logic [AW-1:0] cnt_q, tgt;
  logic          armed_q, bypass;

  always_comb begin
    unique case (sel_i)
      2'b01:   tgt = AW'(ARM_UNIT_TICKS);
      2'b10:   tgt = AW'(2 * ARM_UNIT_TICKS);
      default: tgt = AW'(4 * ARM_UNIT_TICKS);
    endcase
  end

  assign bypass = !mode_i || (sel_i == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!pwr_good_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!armed_q) begin
      if (bypass) armed_q <= 1'b1;
      else if (tick_i) begin
        if (cnt_q == tgt - AW'(1)) armed_q <= 1'b1;
        else                       cnt_q   <= cnt_q + AW'(1);
      end
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/vprot_hold.sv
module vprot_hold #(
  parameter int unsigned HALF_SEC_TICKS = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       fault_i,
  input  logic [1:0] sel_i,
  output logic       active_o
);
  localparam int unsigned HW = $clog2(8 * HALF_SEC_TICKS + 1);

  logic [HW-1:0] cnt_q, tgt_q, tgt;
  logic          active_q;

  always_comb begin
    unique case (sel_i)
      2'b00:   tgt = HW'(HALF_SEC_TICKS);
      2'b01:   tgt = HW'(2 * HALF_SEC_TICKS);
      2'b10:   tgt = HW'(4 * HALF_SEC_TICKS);
      default: tgt = HW'(8 * HALF_SEC_TICKS);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      tgt_q    <= '0;
    end else if (!active_q) begin
      if (fault_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        tgt_q    <= tgt;
      end
    end else if (tick_i) begin
      // faults during the hold are ignored here
      if (cnt_q == tgt_q - HW'(1)) active_q <= 1'b0;
      else                         cnt_q    <= cnt_q + HW'(1);
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/vprot_shutdown.sv
module vprot_shutdown
  import vprot_pkg::*;
#(
  parameter int unsigned HALF_SEC_TICKS = 500,
  parameter int unsigned ARM_UNIT_TICKS = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pwr_good_i,
  input  logic             prot_mode_i,
  input  logic [NRAIL-1:0] ov_i,
  input  logic [NRAIL-1:0] uv_i,
  input  logic             slp_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic             psu_on_o,
  output logic             psu_on_oe_o
);
  logic [NRAIL-1:0] en_w;
  cfg_t             cfg_w;
  logic             stat_w, armed_w, fault_w, hold_w;

  assign fault_w = armed_w && pwr_good_i && |((ov_i | uv_i) & en_w);

  vprot_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .fault_i (fault_w),
    .rdata_o (reg_rdata_o),
    .en_o    (en_w),
    .cfg_o   (cfg_w),
    .stat_o  (stat_w)
  );

  vprot_arm #(.ARM_UNIT_TICKS(ARM_UNIT_TICKS)) u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .pwr_good_i (pwr_good_i),
    .mode_i     (prot_mode_i),
    .sel_i      (cfg_w.arm_sel),
    .armed_o    (armed_w)
  );

  vprot_hold #(.HALF_SEC_TICKS(HALF_SEC_TICKS)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .fault_i  (fault_w),
    .sel_i    (cfg_w.hold_sel),
    .active_o (hold_w)
  );

  assign psu_on_oe_o = !hold_w;
  assign psu_on_o    = !slp_i;
endmodule

// File: rtl/vprot_chk.sv
module vprot_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_good_i,
  input logic       reg_we_i,
  input logic [1:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       psu_on_oe_o,
  input logic       stat_q,
  input logic       armed_q,
  input logic       fault_w
);
  logic clr_wr;
  assign clr_wr = reg_we_i && (reg_addr_i == 2'd1) && reg_wdata_i[0];

  p_oe_fall_sets_stat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(psu_on_oe_o) |-> stat_q);

  p_stat_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !clr_wr) |=> stat_q);

  p_stat_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !fault_w) |=> !stat_q);

  p_no_set_unpowered_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q) |-> $past(pwr_good_i));

  p_pg_low_disarms_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !armed_q);

  p_hold_min_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(psu_on_oe_o) |=> !psu_on_oe_o);

  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd0) |-> ((reg_rdata_o & 8'h9E) == 8'h00));
endmodule

bind vprot_shutdown vprot_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwr_good_i  (pwr_good_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .psu_on_oe_o (psu_on_oe_o),
  .stat_q      (stat_w),
  .armed_q     (armed_w),
  .fault_w     (fault_w)
);

// File: tb/tb_vprot_shutdown.sv
`timescale 1ns/1ps
module tb_vprot_shutdown;
  localparam int unsigned H = 8;
  localparam int unsigned A = 4;

  logic       clk = 1'b0, rst_ni = 1'b0, tick = 1'b1, pg = 1'b0, mode = 1'b0, slp = 1'b0;
  logic [2:0] ov = '0, uv = '0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       psu_on, psu_oe;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  vprot_shutdown #(.HALF_SEC_TICKS(H), .ARM_UNIT_TICKS(A)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .pwr_good_i(pg), .prot_mode_i(mode),
    .ov_i(ov), .uv_i(uv), .slp_i(slp), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .psu_on_o(psu_on), .psu_on_oe_o(psu_oe)
  );

  typedef struct packed {
    logic        mode;
    logic [1:0]  asel;
    logic [1:0]  hsel;
    int unsigned earm;
    int unsigned ehold;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'b00, 2'b00, 1,     H},
    '{1'b1, 2'b01, 2'b01, A,     2 * H},
    '{1'b1, 2'b10, 2'b10, 2 * A, 4 * H},
    '{1'b1, 2'b11, 2'b11, 4 * A, 8 * H},
    '{1'b0, 2'b11, 2'b00, 1,     H},
    '{1'b0, 2'b10, 2'b01, 1,     2 * H}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #0.5; d = rdata;
  endtask

  // counts samples with oe high after power-good rises with a fault held, then the hold length
  task automatic measure(output int n_arm, output int n_hold);
    @(negedge clk); pg = 1'b1; ov[0] = 1'b1;
    n_arm = 0;
    do begin @(negedge clk); if (psu_oe) n_arm++; end while (psu_oe && n_arm < 1000);
    ov[0] = 1'b0;
    n_hold = 1;
    do begin @(negedge clk); if (!psu_oe) n_hold++; end while (!psu_oe && n_hold < 1000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int na, nh;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(2'd0, d); chk("R1 enable", d, 8'h00);
    rd(2'd1, d); chk("R1 status", d, 8'h00);
    rd(2'd2, d); chk("R1 config", d, 8'h06);
    chk("R1 oe", psu_oe, 1);
    chk("R1 data", psu_on, 1);

    // R2 enable bit layout
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 all", d, 8'h61);
    wr(2'd0, 8'h9E); rd(2'd0, d); chk("R2 reserved", d, 8'h00);
    rd(2'd3, d); chk("R2 addr3", d, 8'h00);

    // R5 flags on disabled rails, then on enabled rail with power-good low
    wr(2'd0, 8'h00); mode = 1'b0;
    @(negedge clk); pg = 1'b1; ov = 3'b111; uv = 3'b111;
    na = 0;
    repeat (10) begin @(negedge clk); if (!psu_oe) na++; end
    chk("R5 disabled oe", na, 0);
    rd(2'd1, d); chk("R5 disabled status", d, 8'h00);
    ov = '0; uv = '0; pg = 1'b0;
    wr(2'd0, 8'h61); uv[2] = 1'b1;
    na = 0;
    repeat (10) begin @(negedge clk); if (!psu_oe) na++; end
    chk("R5 pg low oe", na, 0);
    rd(2'd1, d); chk("R5 pg low status", d, 8'h00);
    uv = '0;

    // R3 under flag on rail 1 (bit 5), mode 0 arms at once
    wr(2'd0, 8'h20);
    @(negedge clk); pg = 1'b1; uv[1] = 1'b1;
    @(negedge clk); chk("R9 R3 oe not yet", psu_oe, 1);
    @(negedge clk); chk("R3 oe low", psu_oe, 0);
    uv[1] = 1'b0;
    rd(2'd1, d); chk("R3 status", d, 8'h01);
    chk("R7 data during hold", psu_on, 1);
    while (!psu_oe) @(negedge clk);

    // R4 clear semantics
    wr(2'd1, 8'h00); rd(2'd1, d); chk("R4 write 0", d, 8'h01);
    wr(2'd1, 8'hFE); rd(2'd1, d); chk("R4 write FE", d, 8'h01);
    wr(2'd1, 8'h01); rd(2'd1, d); chk("R4 clear", d, 8'h00);

    // R7 follows sleep input
    slp = 1'b1; #0.5; chk("R7 slp1", psu_on, 0);
    slp = 1'b0; #0.5; chk("R7 slp0", psu_on, 1);

    // table walk: R6 hold lengths, R8 / R9 arming
    wr(2'd0, 8'h01);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); pg = 1'b0; mode = VEC[i].mode;
      wr(2'd2, {4'h0, VEC[i].hsel, VEC[i].asel});
      wr(2'd1, 8'h01);
      measure(na, nh);
      chk(VEC[i].mode && VEC[i].asel != 2'b00 ? "R8 arm delay" : "R9 arm bypass", na, VEC[i].earm);
      chk("R6 hold length", nh, VEC[i].ehold);
      rd(2'd1, d); chk("R3 status after hold", d, 8'h01);
    end

    // R10 second fault on rail 2 during hold
    @(negedge clk); pg = 1'b0; mode = 1'b0;
    wr(2'd0, 8'h41); wr(2'd2, 8'h00);
    @(negedge clk); pg = 1'b1;
    @(negedge clk); ov[0] = 1'b1;
    @(negedge clk); ov[0] = 1'b0;
    nh = 0;
    for (int k = 0; k < 40; k++) begin
      if (k == 3) ov[2] = 1'b1;
      if (k == 4) ov[2] = 1'b0;
      if (!psu_oe) nh++;
      @(negedge clk);
    end
    chk("R10 no restart", nh, H);

    // R11 dropout restarts arming
    pg = 1'b0; mode = 1'b1;
    wr(2'd2, 8'h01);
    @(negedge clk); pg = 1'b1;
    repeat (2) @(negedge clk);
    pg = 1'b0;
    @(negedge clk);
    measure(na, nh);
    chk("R11 rearm delay", na, A);
    chk("R11 hold", nh, H);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule